// File: doc/BRIEF.md
# Frame Capture Arming Controller

This block arms a single-frame capture into an external frame FIFO. A host pulses a capture request; the block marks itself busy and waits for the next falling edge of the camera's vertical sync. At that edge it opens the FIFO write-enable for exactly one frame. At the following falling edge it closes the enable, drops busy and raises a done flag. The host polls done with a read-clear strobe. The done flag stays hidden while the block is busy, and a poll that sees it clears it.

The block also counts line-valid rising edges within each frame. At every vertical-sync falling edge it latches the count of the frame just ended into a last-frame register and restarts the count. Both camera strobes are asynchronous. Each passes through a two-flop synchroniser before its edges are detected, so every reaction to them comes three clock edges after the pin changes.

Top module: `frame_arm_ctrl`

## Requirements
- R1: While reset is held, fifo_wen_o, busy_o and done_o are low and last_lines_o is zero.
- R2: A cycle with req_i high makes busy_o high from the next clock edge, and registers a pending request.
- R3: A synchronised vsync_i falling edge with a request pending sets fifo_wen_o, clears the pending request and clears the done flag. The edge acts three clock edges after the pin falls.
- R4: A synchronised vsync_i falling edge with no request pending clears fifo_wen_o. If the block was busy, busy_o falls and done_o rises on the same edge.
- R5: done_o is low while busy_o is high. A poll_i strobe while busy_o is low clears done_o from the next edge. A poll_i strobe while busy_o is high changes neither busy_o nor fifo_wen_o.
- R6: Each synchronised href_i rising edge adds one to the line count. The count saturates at 2^LINE_W-1 and never wraps.
- R7: At each synchronised vsync_i falling edge, last_lines_o takes the count of the ending frame and the count restarts. An href_i rising edge on that same cycle counts as line one of the new frame.
- R8: If req_i is high in the same cycle that a vsync_i falling edge acts, the edge is handled as though no request were pending. The request arms on the following falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Capture request pulse from the host |
| vsync_i | input | 1 | Camera vertical sync, asynchronous |
| href_i | input | 1 | Camera line valid, asynchronous |
| poll_i | input | 1 | Read-clear strobe for the done flag |
| fifo_wen_o | output | 1 | FIFO write-enable, high for one whole frame |
| busy_o | output | 1 | Capture requested or in progress |
| done_o | output | 1 | Capture finished and not yet polled |
| last_lines_o | output | LINE_W | Line count of the last complete frame |

## Verification
The assertions assume that req_i and poll_i are synchronous to clk. They also assume that the camera strobes are wide enough to survive the synchroniser, which means each level lasts at least two clock cycles. The stimulus drives every input at the falling clock edge and holds each vsync and href level for three or more cycles. It places requests and polls at chosen offsets from the synchronised vsync edge, including the exact cycle in which that edge acts.

// File: rtl/frame_arm_pkg.sv
package frame_arm_pkg;

    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    typedef struct packed {
        logic pending;
        logic busy;
        logic done;
        logic wen;
    } arm_t;

    localparam arm_t ARM_IDLE = '0;

endpackage

// File: rtl/frame_edge_sync.sv
module frame_edge_sync
    import frame_arm_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  d_i,
    output edge_t edge_o
);
    localparam int PW = STAGES + 1;

    // pipe[STAGES-1] is the synchronised level, pipe[STAGES] its previous value
    logic [PW-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[PW-2:0], d_i};
    end

    always_comb begin
        edge_o.rise = pipe[STAGES-1] & ~pipe[STAGES];
        edge_o.fall = ~pipe[STAGES-1] & pipe[STAGES];
    end
endmodule

// File: rtl/frame_line_tally.sv
module frame_line_tally #(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_rise,
    input  logic              frame_fall,
    output logic [LINE_W-1:0] cnt_o,
    output logic [LINE_W-1:0] last_o
);
    localparam logic [LINE_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o  <= '0;
            last_o <= '0;
        end else if (frame_fall) begin
            last_o <= cnt_o;
            cnt_o  <= LINE_W'(line_rise);
        end else if (line_rise && cnt_o != CNT_MAX) begin
            cnt_o  <= cnt_o + 1'b1;
        end
    end
endmodule

// File: rtl/frame_arm_fsm.sv
module frame_arm_fsm
    import frame_arm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic poll,
    input  logic frame_fall,
    output arm_t st_o
);
    arm_t nxt;

    always_comb begin
        nxt = st_o;
        if (poll && !st_o.busy) nxt.done = 1'b0;
        if (frame_fall) begin
            if (st_o.pending) begin
                nxt.wen     = 1'b1;
                nxt.done    = 1'b0;
                nxt.pending = 1'b0;
            end else begin
                nxt.wen = 1'b0;
                if (st_o.busy) begin
                    nxt.busy = 1'b0;
                    nxt.done = 1'b1;
                end
            end
        end
        // a request in the edge cycle lands after it: armed next frame
        if (req) begin
            nxt.pending = 1'b1;
            nxt.busy    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_o <= ARM_IDLE;
        else     st_o <= nxt;
    end
endmodule

// File: rtl/frame_arm_ctrl.sv
module frame_arm_ctrl
    import frame_arm_pkg::*;
#(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              vsync_i,
    input  logic              href_i,
    input  logic              poll_i,
    output logic              fifo_wen_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [LINE_W-1:0] last_lines_o
);
    localparam int NSIG = 2;

    logic [NSIG-1:0] raw;
    edge_t           edges [NSIG];
    logic            vs_fall;
    logic            hr_rise;
    logic [LINE_W-1:0] line_cnt;
    arm_t            st;
    logic            unused_bits;

    assign raw = {href_i, vsync_i};

    for (genvar g = 0; g < NSIG; g++) begin : g_sync
        frame_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst    (rst),
            .d_i    (raw[g]),
            .edge_o (edges[g])
        );
    end

    assign vs_fall = edges[0].fall;
    assign hr_rise = edges[1].rise;
    assign unused_bits = &{1'b0, edges[0].rise, edges[1].fall, st.pending};

    frame_line_tally #(.LINE_W(LINE_W)) u_tally (
        .clk        (clk),
        .rst        (rst),
        .line_rise  (hr_rise),
        .frame_fall (vs_fall),
        .cnt_o      (line_cnt),
        .last_o     (last_lines_o)
    );

    frame_arm_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req        (req_i),
        .poll       (poll_i),
        .frame_fall (vs_fall),
        .st_o       (st)
    );

    assign fifo_wen_o = st.wen;
    assign busy_o     = st.busy;
    assign done_o     = st.done & ~st.busy;
endmodule

// File: rtl/frame_arm_chk.sv
module frame_arm_chk #(
    parameter int LINE_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              req_i,
    input logic              poll_i,
    input logic              fifo_wen_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              vs_fall,
    input logic [LINE_W-1:0] line_cnt
);
    localparam logic [LINE_W-1:0] CNT_MAX = '1;

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!fifo_wen_o && !busy_o && !done_o));

    a_r2_req_sets_busy: assert property (@(posedge clk) disable iff (rst)
        req_i |=> busy_o);

    a_r3_wen_only_on_fall: assert property (@(posedge clk) disable iff (rst)
        !vs_fall |=> $stable(fifo_wen_o));

    a_r4_done_when_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);

    a_r5_poll_clears: assert property (@(posedge clk) disable iff (rst)
        (poll_i && !busy_o) |=> !done_o);

    a_r6_count_monotonic: assert property (@(posedge clk) disable iff (rst)
        !vs_fall |=> line_cnt >= $past(line_cnt));

    a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (line_cnt == CNT_MAX && !vs_fall) |=> line_cnt == CNT_MAX);
endmodule

bind frame_arm_ctrl frame_arm_chk #(.LINE_W(LINE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req_i),
    .poll_i     (poll_i),
    .fifo_wen_o (fifo_wen_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .vs_fall    (vs_fall),
    .line_cnt   (line_cnt)
);

// File: tb/frame_arm_ctrl_test.sv
module frame_arm_ctrl_test;
    localparam int LW  = 6;
    localparam int MAXC = (1 << LW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_i = 1'b0, vsync_i = 1'b0, href_i = 1'b0, poll_i = 1'b0;
    logic fifo_wen_o, busy_o, done_o;
    logic [LW-1:0] last_lines_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    bit running  = 0;

    always #2 clk = ~clk;

    frame_arm_ctrl #(.LINE_W(LW)) uut (
        .clk(clk), .rst(rst), .req_i(req_i), .vsync_i(vsync_i),
        .href_i(href_i), .poll_i(poll_i), .fifo_wen_o(fifo_wen_o),
        .busy_o(busy_o), .done_o(done_o), .last_lines_o(last_lines_o)
    );

    // behavioural reference: inputs seen three edges late
    bit vq[$];
    bit hq[$];
    bit m_pend, m_busy, m_done, m_wen;
    int m_cnt, m_last;

    always @(posedge clk) begin
        bit vf, hr, p, b, d, w;
        int c, l;
        if (rst) begin
            vq = '{1'b0, 1'b0, 1'b0};
            hq = '{1'b0, 1'b0, 1'b0};
            m_pend = 0; m_busy = 0; m_done = 0; m_wen = 0;
            m_cnt = 0; m_last = 0;
        end else begin
            vf = vq[0] && !vq[1];
            hr = !hq[0] && hq[1];
            p = m_pend; b = m_busy; d = m_done; w = m_wen; c = m_cnt; l = m_last;
            if (poll_i && !m_busy) d = 0;
            if (vf) begin
                if (m_pend) begin w = 1; d = 0; p = 0; end
                else begin
                    w = 0;
                    if (m_busy) begin b = 0; d = 1; end
                end
                l = m_cnt;
                c = hr ? 1 : 0;
            end else if (hr && m_cnt < MAXC) c = m_cnt + 1;
            if (req_i) begin p = 1; b = 1; end
            m_pend = p; m_busy = b; m_done = d; m_wen = w; m_cnt = c; m_last = l;
            vq.push_back(vsync_i); void'(vq.pop_front());
            hq.push_back(href_i);  void'(hq.pop_front());
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (running && !rst) begin
            check(fifo_wen_o == m_wen, "R3/R4 wen vs model", fifo_wen_o, m_wen);
            check(busy_o == m_busy, "R2/R4 busy vs model", busy_o, m_busy);
            check(done_o == (m_done && !m_busy), "R5 done vs model", done_o, m_done && !m_busy);
            check(int'(last_lines_o) == m_last, "R7 last lines vs model", last_lines_o, m_last);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req();
        req_i = 1'b1; step(1); req_i = 1'b0;
    endtask

    task automatic pulse_poll();
        poll_i = 1'b1; step(1); poll_i = 1'b0;
    endtask

    // vsync high gap, falling edge, then n lines
    task automatic frame(input int n);
        vsync_i = 1'b1; step(4);
        vsync_i = 1'b0; step(4);
        for (int i = 0; i < n; i++) begin
            href_i = 1'b1; step(3);
            href_i = 1'b0; step(3);
        end
        step(2);
    endtask

    initial begin
        step(3);
        check(fifo_wen_o == 0 && busy_o == 0 && done_o == 0, "R1 outputs in reset",
              {fifo_wen_o, busy_o, done_o}, 0);
        check(last_lines_o == 0, "R1 last lines in reset", last_lines_o, 0);
        rst = 1'b0;
        running = 1;
        step(2);

        frame(3);
        check(fifo_wen_o == 0, "R4 no request keeps wen low", fifo_wen_o, 0);
        frame(2);
        check(last_lines_o == 3, "R7 last lines after 3-line frame", last_lines_o, 3);

        pulse_req();
        check(busy_o == 1, "R2 busy after request", busy_o, 1);
        check(fifo_wen_o == 0, "R2 wen waits for vsync", fifo_wen_o, 0);
        pulse_poll();
        check(busy_o == 1 && fifo_wen_o == 0, "R5 poll while busy has no effect",
              {busy_o, fifo_wen_o}, 2);
        frame(5);
        check(fifo_wen_o == 1, "R3 wen open during captured frame", fifo_wen_o, 1);
        check(done_o == 0, "R5 done hidden while busy", done_o, 0);
        frame(4);
        check(fifo_wen_o == 0 && busy_o == 0, "R4 capture closes", {fifo_wen_o, busy_o}, 0);
        check(done_o == 1, "R4 done after busy clears", done_o, 1);
        check(last_lines_o == 5, "R7 last lines of captured frame", last_lines_o, 5);
        pulse_poll();
        check(done_o == 0, "R5 poll clears done", done_o, 0);

        // request in the exact cycle the synchronised fall acts
        vsync_i = 1'b1; step(4);
        vsync_i = 1'b0; step(2);
        pulse_req();
        check(fifo_wen_o == 0 && busy_o == 1, "R8 coincident request deferred",
              {fifo_wen_o, busy_o}, 1);
        step(6);
        frame(2);
        check(fifo_wen_o == 1, "R8 deferred request armed next frame", fifo_wen_o, 1);
        frame(1);
        check(done_o == 1, "R4 done after deferred capture", done_o, 1);
        pulse_poll();

        frame(MAXC + 7);
        frame(0);
        check(int'(last_lines_o) == MAXC, "R6 line count saturates", last_lines_o, MAXC);
        frame(0);
        check(last_lines_o == 0, "R7 empty frame counts zero", last_lines_o, 0);

        step(4);
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule